// File: doc/BRIEF.md
# Transport packet sync state machine

This block finds and keeps the byte alignment of 204-byte coded transport packets: 188 payload bytes followed by 16 parity bytes. It sits in front of a convolutional deinterleaver. It watches a byte stream qualified by a valid strobe. A byte only counts when the strobe is high.

While searching, any byte equal to the sync value 0x47, or to its bitwise inverse 0xB8, opens a candidate alignment. The block then checks the byte 204 valid bytes later, and again every 204 valid bytes after that. Once a programmable number of consecutive sync hits has been seen, the block declares lock and moves to tracking.

During tracking it counts consecutive packet slots whose first byte is not a sync. When that count reaches a second programmable limit, it drops lock and searches again. A single good sync clears the count.

While locked, the block gives downstream logic three things:
- a packet-start pulse for every packet slot;
- a flag marking slots whose sync byte was inverted;
- the index of the current byte within the packet.

Top module: `pkt_sync_fsm`

## Requirements
- R1: After reset, locked_o, pkt_start_o and inv_sync_o are 0 and byte_idx_o is 0.
- R2: While searching (not locked, no candidate), a valid byte equal to 0x47 or 0xB8 starts a candidate alignment and is given index 0. Other valid bytes keep byte_idx_o at 0.
- R3: Once aligned (candidate or locked), byte_idx_o counts valid bytes 0 to 203 and wraps 203 to 0. The byte that gets index 0 is the sync slot, exactly 204 valid bytes after the previous slot.
- R4: Lock is declared on the slot that completes acq_thr_i consecutive sync hits, counting the candidate-opening byte. An acq_thr_i of 0 acts as 1, which means the opening byte locks at once.
- R5: Before lock, a slot whose byte is not a sync drops the candidate and returns to search. Sync values at any other position are ignored.
- R6: While locked, each slot without a sync adds one to a miss count. When the count reaches loss_thr_i, with 0 acting as 1, locked_o falls after that byte and byte_idx_o returns to 0.
- R7: While locked, a slot holding a sync value clears the miss count.
- R8: pkt_start_o is high for one cycle after each slot byte that leaves the block locked. This covers the locking byte and missed slots below the loss limit. inv_sync_o is high with it exactly when that byte was 0xB8.
- R9: A cycle with valid_i low changes no state, whatever data_i holds. In the following cycle pkt_start_o and inv_sync_o are 0, and locked_o and byte_idx_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Incoming byte |
| valid_i | input | 1 | data_i carries a byte this cycle |
| acq_thr_i | input | 3 | Consecutive sync hits needed for lock (0 acts as 1) |
| loss_thr_i | input | 3 | Consecutive missed syncs that drop lock (0 acts as 1) |
| locked_o | output | 1 | Alignment locked |
| pkt_start_o | output | 1 | One-cycle pulse per packet slot while locked |
| inv_sync_o | output | 1 | The slot marked by pkt_start_o held 0xB8 |
| byte_idx_o | output | 8 | Index in the packet of the last accepted byte |

## Verification
Several packet patterns are used:
- Filler bytes with no sync show that search does not advance.
- Sequences of normal and inverted syncs at the exact 204-byte spacing show acquisition, and the inverted flag.
- A candidate followed by a slot without a sync shows that a false candidate is dropped.
- During tracking, a miss followed by a good sync and then two misses tells a cleared miss count apart from one that was never cleared.
- Stray sync values placed mid-packet, and idle cycles that carry sync values, show that only valid slot bytes matter.
- Zero thresholds show that 0 is treated as 1.

// File: rtl/pkt_sync_pkg.sv
package pkt_sync_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_TRACK  = 2'd2
  } sync_state_e;
endpackage

// File: rtl/sync_match.sv
module sync_match #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] SYNC_VAL = 8'h47
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_norm_o,
  output logic              hit_inv_o
);
  localparam logic [DATA_W-1:0] SYNC_INV = ~SYNC_VAL;

  assign hit_norm_o = (data_i == SYNC_VAL);
  assign hit_inv_o  = (data_i == SYNC_INV);
endmodule

// File: rtl/byte_pos_ctr.sv
module byte_pos_ctr #(
  parameter int unsigned PKT_LEN = 204,
  parameter int unsigned IDX_W   = $clog2(PKT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             aligned_i,
  output logic [IDX_W-1:0] pos_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(PKT_LEN - 1);

  assign last_o = (pos_o == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
    end else if (valid_i) begin
      if (!aligned_i || last_o) pos_o <= '0;
      else                      pos_o <= pos_o + 1'b1;
    end
  end

  // R3
  pos_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= LAST_POS);

  // R9
  pos_hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pos_o));
endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import pkt_sync_pkg::*;
#(
  parameter int unsigned THR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             hit_i,
  input  logic             inv_i,
  input  logic             last_i,
  input  logic [THR_W-1:0] acq_thr_i,
  input  logic [THR_W-1:0] loss_thr_i,
  output logic             aligned_o,
  output logic             locked_o,
  output logic             pkt_start_o,
  output logic             inv_sync_o
);
  localparam int unsigned CNT_W = THR_W + 1;

  sync_state_e      state_q;
  logic [THR_W-1:0] hits_q, miss_q;
  logic [CNT_W-1:0] acq_eff, loss_eff, hits_inc, miss_inc;

  assign acq_eff  = (acq_thr_i  == '0) ? CNT_W'(1) : {1'b0, acq_thr_i};
  assign loss_eff = (loss_thr_i == '0) ? CNT_W'(1) : {1'b0, loss_thr_i};
  assign hits_inc = {1'b0, hits_q} + 1'b1;
  assign miss_inc = {1'b0, miss_q} + 1'b1;

  assign aligned_o = (state_q != ST_SEARCH);
  assign locked_o  = (state_q == ST_TRACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_SEARCH;
      hits_q      <= '0;
      miss_q      <= '0;
      pkt_start_o <= 1'b0;
      inv_sync_o  <= 1'b0;
    end else begin
      pkt_start_o <= 1'b0;
      inv_sync_o  <= 1'b0;
      if (valid_i) begin
        unique case (state_q)
          ST_SEARCH: begin
            if (hit_i) begin
              hits_q <= THR_W'(1);
              miss_q <= '0;
              if (acq_eff == CNT_W'(1)) begin
                state_q     <= ST_TRACK;
                pkt_start_o <= 1'b1;
                inv_sync_o  <= inv_i;
              end else begin
                state_q <= ST_VERIFY;
              end
            end
          end
          ST_VERIFY: begin
            if (last_i) begin
              if (hit_i) begin
                hits_q <= hits_inc[THR_W-1:0];
                if (hits_inc >= acq_eff) begin
                  state_q     <= ST_TRACK;
                  pkt_start_o <= 1'b1;
                  inv_sync_o  <= inv_i;
                end
              end else begin
                state_q <= ST_SEARCH;
              end
            end
          end
          ST_TRACK: begin
            if (last_i) begin
              if (hit_i) begin
                miss_q      <= '0;
                pkt_start_o <= 1'b1;
                inv_sync_o  <= inv_i;
              end else if (miss_inc >= loss_eff) begin
                state_q <= ST_SEARCH;
                miss_q  <= '0;
              end else begin
                miss_q      <= miss_inc[THR_W-1:0];
                pkt_start_o <= 1'b1;
              end
            end
          end
          default: state_q <= ST_SEARCH;
        endcase
      end
    end
  end

  // R8
  start_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> locked_o);

  // R8
  inv_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_sync_o |-> pkt_start_o);

  // R4
  lock_marks_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> pkt_start_o);

  // R9
  idle_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !pkt_start_o && $stable(state_q));

  // R5
  verify_miss_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VERIFY && valid_i && last_i && !hit_i) |=> !aligned_o);
endmodule

// File: rtl/pkt_sync_fsm.sv
module pkt_sync_fsm #(
  parameter int unsigned PKT_LEN  = 204,
  parameter int unsigned THR_W    = 3,
  parameter logic [7:0]  SYNC_VAL = 8'h47,
  parameter int unsigned IDX_W    = $clog2(PKT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  input  logic [THR_W-1:0] acq_thr_i,
  input  logic [THR_W-1:0] loss_thr_i,
  output logic             locked_o,
  output logic             pkt_start_o,
  output logic             inv_sync_o,
  output logic [IDX_W-1:0] byte_idx_o
);
  logic hit_norm, hit_inv, aligned, last;

  sync_match #(.DATA_W(8), .SYNC_VAL(SYNC_VAL)) u_match (
    .data_i     (data_i),
    .hit_norm_o (hit_norm),
    .hit_inv_o  (hit_inv)
  );

  byte_pos_ctr #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .aligned_i (aligned),
    .pos_o     (byte_idx_o),
    .last_o    (last)
  );

  sync_ctrl #(.THR_W(THR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .hit_i       (hit_norm | hit_inv),
    .inv_i       (hit_inv),
    .last_i      (last),
    .acq_thr_i   (acq_thr_i),
    .loss_thr_i  (loss_thr_i),
    .aligned_o   (aligned),
    .locked_o    (locked_o),
    .pkt_start_o (pkt_start_o),
    .inv_sync_o  (inv_sync_o)
  );

  // R6
  loss_resets_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> byte_idx_o == '0);
endmodule

// File: tb/tb_pkt_sync_fsm.sv
`timescale 1ns/1ps
module tb_pkt_sync_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = 8'h00;
  logic       valid = 1'b0;
  logic [2:0] acq_thr = 3'd3, loss_thr = 3'd2;
  logic       locked, pkt_start, inv_sync;
  logic [7:0] byte_idx;

  int total = 0, bad = 0;
  bit done = 0;

  logic       q_lk[$], q_st[$], q_iv[$];
  logic [7:0] q_idx[$];
  string      q_tag[$];
  logic       e_lock = 1'b0;
  logic [7:0] e_idx = 8'd0;

  always #2.5 clk = ~clk;

  pkt_sync_fsm dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .acq_thr_i(acq_thr), .loss_thr_i(loss_thr),
    .locked_o(locked), .pkt_start_o(pkt_start), .inv_sync_o(inv_sync),
    .byte_idx_o(byte_idx)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic lk, st, iv, input logic [7:0] idx, input string tag);
    q_lk.push_back(lk); q_st.push_back(st); q_iv.push_back(iv);
    q_idx.push_back(idx); q_tag.push_back(tag);
  endtask

  task automatic drive(input logic [7:0] b, input logic lk, st, iv,
                       input logic [7:0] idx, input string tag);
    @(negedge clk);
    data = b; valid = 1'b1;
    e_lock = lk; e_idx = idx;
    push(lk, st, iv, idx, tag);
  endtask

  // R9: idle cycle carrying a sync value must be ignored
  task automatic drive_idle(input logic [7:0] b);
    @(negedge clk);
    data = b; valid = 1'b0;
    push(e_lock, 1'b0, 1'b0, e_idx, "R9 idle");
  endtask

  task automatic send_pkt(input logic [7:0] first, input logic lk, st, iv, al,
                          input bit mid, gaps, input string tag);
    for (int i = 0; i < 204; i++) begin
      logic [7:0] b;
      b = (i == 0) ? first : (mid && i == 100) ? 8'h47 : 8'((i % 64) + 1);
      if (gaps && (i % 50) == 25) drive_idle(8'hB8);
      if (i == 0) drive(b, lk, st, iv, 8'd0, tag);
      else        drive(b, lk, 1'b0, 1'b0, al ? 8'(i) : 8'd0, tag);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      check({t, " locked"},    {7'd0, locked},    {7'd0, q_lk.pop_front()});
      check({t, " pkt_start"}, {7'd0, pkt_start}, {7'd0, q_st.pop_front()});
      check({t, " inv_sync"},  {7'd0, inv_sync},  {7'd0, q_iv.pop_front()});
      check({t, " byte_idx"},  byte_idx,          q_idx.pop_front());
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    check("R1 locked", {7'd0, locked}, 8'd0);
    check("R1 pkt_start", {7'd0, pkt_start}, 8'd0);
    check("R1 inv_sync", {7'd0, inv_sync}, 8'd0);
    check("R1 byte_idx", byte_idx, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    // search with filler: nothing happens
    for (int i = 0; i < 10; i++) drive(8'h12, 1'b0, 1'b0, 1'b0, 8'd0, "R2 filler");
    // acq=3, loss=2
    send_pkt(8'h47, 0, 0, 0, 1, 0, 0, "R2 R3 candidate");
    send_pkt(8'hB8, 0, 0, 0, 1, 0, 0, "R3 second hit");
    send_pkt(8'h47, 1, 1, 0, 1, 0, 0, "R4 lock");
    send_pkt(8'hB8, 1, 1, 1, 1, 0, 0, "R8 inverted");
    send_pkt(8'h00, 1, 1, 0, 1, 0, 0, "R6 R8 miss one");
    send_pkt(8'h47, 1, 1, 0, 1, 0, 0, "R7 clear");
    send_pkt(8'h00, 1, 1, 0, 1, 0, 0, "R7 miss after clear");
    send_pkt(8'h00, 0, 0, 0, 0, 0, 0, "R6 loss");

    // zero thresholds act as 1
    @(negedge clk); acq_thr = 3'd0; loss_thr = 3'd0;
    push(e_lock, 1'b0, 1'b0, e_idx, "R9 hold"); valid = 1'b0;
    send_pkt(8'hB8, 1, 1, 1, 1, 0, 0, "R4 zero acq");
    send_pkt(8'h00, 0, 0, 0, 0, 0, 0, "R6 zero loss");

    // off-slot syncs and idle cycles ignored
    @(negedge clk); acq_thr = 3'd2; loss_thr = 3'd3;
    push(e_lock, 1'b0, 1'b0, e_idx, "R9 hold"); valid = 1'b0;
    send_pkt(8'h47, 0, 0, 0, 1, 1, 1, "R5 R9 candidate gaps");
    send_pkt(8'h00, 0, 0, 0, 0, 0, 0, "R5 false candidate");
    send_pkt(8'h47, 0, 0, 0, 1, 1, 0, "R2 new candidate");
    send_pkt(8'hB8, 1, 1, 1, 1, 1, 1, "R4 R9 lock gaps");
    send_pkt(8'h47, 1, 1, 0, 1, 0, 1, "R8 R3 track");

    drive_idle(8'h47);
    drive_idle(8'h47);
    repeat (3) @(posedge clk);
    #2;
    check("R9 queue drained", 8'(q_tag.size()), 8'd0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule